// File: doc/BRIEF.md
# Cache maintenance range sequencer

This block carries out a cache clean, flush or invalidate over a byte range. The range runs from the first operand A up to, but not including, the second operand B. It breaks the range into cache lines and sends one maintenance command per line to the cache controller. Before it sends the first command that falls in a page, it asks the translation unit whether that page may be touched. Each call sends only a limited number of commands. The call then ends with a progress address X. Software calls again with A set to X and the same B, and it keeps doing so until X equals B.

An empty range returns B at once. Under invalidate, a line that the range covers only in part is sent as a flush command, so that bytes outside the range are written back and not lost. A page that fails the translation check ends the call with a fault. A parameter turns on an internal resume pointer. With it set, an unfinished call returns the original A, and the repeated call continues from where the last one stopped. Another parameter marks the memory system as fully coherent. In that mode every call returns B and sends nothing out.

Top module: `lms_range_seq`

## Requirements
- R1: When B <= A (unsigned), the call ends with X = B, fault low, and no line command.
- R2: Line commands carry line-aligned addresses. Within one range they cover every line that overlaps [A, B), in ascending order, each line once across all calls.
- R3: The operation code is 0 for clean, 1 for flush and 2 for invalidate. Clean and flush pass to every line unchanged, and invalidate passes unchanged to every line that lies wholly inside the range.
- R4: Under invalidate, a line is sent as flush (code 1) when the range starts inside it or ends before its last byte.
- R5: A call sends at most BUDGET line commands. Without the resume pointer, an unfinished call returns the line boundary that follows the last line it sent, and a finished call returns exactly B.
- R6: Calling again with A = X and the same B ends after a finite number of calls with X = B, once every line has been sent.
- R7: A page check for a page is answered before any line command in that page, including the first page of the call. The checked page number is the address bits above the page offset.
- R8: A failed page check ends the call with fault high and X equal to the first unprocessed address, and no command is sent for that page.
- R9: In the coherent configuration every call returns B, and the block raises neither line commands nor page checks.
- R10: With the resume pointer enabled, a call that stops early returns the original A, and the identical repeated call continues from the next unsent line.
- R11: A line command request stays asserted, with the same address and code, until it is accepted.
- R12: After reset the block is idle with no request raised. done is high for exactly one cycle, and X and fault hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a call; taken only while busy is low |
| op | input | 2 | Operation: 0 clean, 1 flush, 2 invalidate |
| addr_a | input | AW | Range start A |
| addr_b | input | AW | Range end B (exclusive) |
| busy | output | 1 | A call is in progress |
| done | output | 1 | One-cycle end-of-call strobe |
| result_x | output | AW | Progress address X |
| fault | output | 1 | The call ended on a failed page check |
| cmd_valid | output | 1 | Line command request |
| cmd_ready | input | 1 | Controller accepts the line command |
| cmd_op | output | 2 | Per-line operation code |
| cmd_addr | output | AW | Line-aligned address |
| chk_req | output | 1 | Page check request |
| chk_ack | input | 1 | Page check answered |
| chk_fault | input | 1 | Page check failed (valid with chk_ack) |
| chk_page | output | AW-PAGE_W | Page number being checked |

## Verification
The main function is swept over every operation code, across a grid of start and end addresses that fall on line boundaries, inside lines, on page boundaries and with the end below the start. This separates full-line from partial-line handling under invalidate, and it separates empty ranges from calls that stop on the budget or on the range end. A range at the top of the address space checks the carry out of the last line boundary. A range with a faulting page shows that commands stop before that page and that X points at its start. Separate instances cover the coherent mode and the resume pointer, the latter showing that repeated calls return A until the final one returns B. Accept signals are withheld on a rotating pattern, so that requests are seen held under back-pressure.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    OP_CLEAN = 2'd0,
    OP_FLUSH = 2'd1,
    OP_INVAL = 2'd2
  } maint_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/lms_line_math.sv
module lms_line_math
  import lms_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LINE_W = 6,
  parameter int PAGE_W = 12
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] bound,
  input  logic [1:0]    op,
  output logic [AW-1:0] line_addr,
  output logic [AW-1:0] x_clamp,
  output logic          last_line,
  output logic          page_cross,
  output logic [1:0]    line_op
);
  localparam int LN = AW - LINE_W;

  logic [AW:0] next_ext;
  logic        partial;

  assign line_addr  = {cur[AW-1:LINE_W], {LINE_W{1'b0}}};
  assign next_ext   = {({1'b0, cur[AW-1:LINE_W]} + (LN+1)'(1)), {LINE_W{1'b0}}};
  assign last_line  = next_ext >= {1'b0, bound};
  assign x_clamp    = last_line ? bound : next_ext[AW-1:0];
  assign page_cross = (next_ext[PAGE_W-1:0] == '0);
  assign partial    = (|cur[LINE_W-1:0]) || (next_ext > {1'b0, bound});
  assign line_op    = (op == OP_INVAL && partial) ? OP_FLUSH : op;
endmodule

// File: rtl/lms_budget.sv
module lms_budget #(
  parameter int BUDGET = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(BUDGET + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(BUDGET - 1));
endmodule

// File: rtl/lms_resume.sv
module lms_resume #(
  parameter int AW    = 32,
  parameter bit TRACK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_in,
  input  logic [AW-1:0] b_in,
  input  logic [1:0]    op_in,
  input  logic          save,
  input  logic          drop,
  input  logic [AW-1:0] save_a,
  input  logic [AW-1:0] save_b,
  input  logic [1:0]    save_op,
  input  logic [AW-1:0] save_cur,
  output logic          hit,
  output logic [AW-1:0] resume_cur
);
  generate
    if (TRACK) begin : g_track
      logic          vld_q;
      logic [AW-1:0] ta_q, tb_q, tc_q;
      logic [1:0]    to_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld_q <= 1'b0;
        else if (save)  vld_q <= 1'b1;
        else if (drop)  vld_q <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ta_q <= '0; tb_q <= '0; tc_q <= '0; to_q <= '0;
        end else if (save) begin
          ta_q <= save_a; tb_q <= save_b; tc_q <= save_cur; to_q <= save_op;
        end
      end

      assign hit        = vld_q && a_in == ta_q && b_in == tb_q && op_in == to_q;
      assign resume_cur = tc_q;
    end else begin : g_plain
      logic unused_in;
      assign unused_in  = ^{clk, rst_n, a_in, b_in, op_in, save, drop,
                            save_a, save_b, save_op, save_cur};
      assign hit        = 1'b0;
      assign resume_cur = '0;
    end
  endgenerate
endmodule

// File: rtl/lms_range_seq.sv
module lms_range_seq
  import lms_pkg::*;
#(
  parameter int AW             = 32,
  parameter int LINE_W         = 6,
  parameter int PAGE_W         = 12,
  parameter int BUDGET         = 8,
  parameter bit COHERENT       = 1'b0,
  parameter bit TRACK_INTERNAL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [AW-1:0]        addr_a,
  input  logic [AW-1:0]        addr_b,
  output logic                 busy,
  output logic                 done,
  output logic [AW-1:0]        result_x,
  output logic                 fault,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [1:0]           cmd_op,
  output logic [AW-1:0]        cmd_addr,
  output logic                 chk_req,
  input  logic                 chk_ack,
  input  logic                 chk_fault,
  output logic [AW-PAGE_W-1:0] chk_page
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] cur_q, cur_d, a_q, a_d, b_q, b_d, x_q, x_d;
  logic [1:0]    op_q, op_d;
  logic          flt_q, flt_d;
  logic          cnt_clr, cnt_inc, budget_last;
  logic          save, drop, hit;
  logic [AW-1:0] resume_cur, x_clamp;
  logic          last_line, page_cross;

  lms_line_math #(.AW(AW), .LINE_W(LINE_W), .PAGE_W(PAGE_W)) u_math (
    .cur(cur_q), .bound(b_q), .op(op_q), .line_addr(cmd_addr),
    .x_clamp(x_clamp), .last_line(last_line), .page_cross(page_cross),
    .line_op(cmd_op)
  );

  lms_budget #(.BUDGET(BUDGET)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .last(budget_last)
  );

  lms_resume #(.AW(AW), .TRACK(TRACK_INTERNAL)) u_resume (
    .clk(clk), .rst_n(rst_n), .a_in(addr_a), .b_in(addr_b), .op_in(op),
    .save(save), .drop(drop), .save_a(a_q), .save_b(b_q), .save_op(op_q),
    .save_cur(x_clamp), .hit(hit), .resume_cur(resume_cur)
  );

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    a_d     = a_q;
    b_d     = b_q;
    op_d    = op_q;
    x_d     = x_q;
    flt_d   = flt_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    save    = 1'b0;
    drop    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        a_d     = addr_a;
        b_d     = addr_b;
        op_d    = op;
        flt_d   = 1'b0;
        cnt_clr = 1'b1;
        cur_d   = hit ? resume_cur : addr_a;
        if (COHERENT || addr_b <= addr_a) begin
          x_d     = addr_b;
          drop    = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: if (chk_ack) begin
        if (chk_fault) begin
          flt_d   = 1'b1;
          x_d     = cur_q;
          drop    = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: if (cmd_ready) begin
        cnt_inc = 1'b1;
        cur_d   = x_clamp;
        if (last_line) begin
          x_d     = b_q;
          drop    = 1'b1;
          state_d = ST_DONE;
        end else if (budget_last) begin
          save    = 1'b1;
          x_d     = TRACK_INTERNAL ? a_q : x_clamp;
          state_d = ST_DONE;
        end else if (page_cross) begin
          state_d = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= '0;
      x_q     <= '0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      a_q     <= a_d;
      b_q     <= b_d;
      op_q    <= op_d;
      x_q     <= x_d;
      flt_q   <= flt_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign cmd_valid = (state_q == ST_ISSUE);
  assign chk_req   = (state_q == ST_CHECK);
  assign chk_page  = cur_q[AW-1:PAGE_W];
  assign result_x  = x_q;
  assign fault     = flt_q;
endmodule

// File: rtl/lms_range_seq_chk.sv
module lms_range_seq_chk #(
  parameter int AW       = 32,
  parameter int PAGE_W   = 12,
  parameter int BUDGET   = 8,
  parameter bit COHERENT = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 fault,
  input logic [AW-1:0]        addr_a,
  input logic [AW-1:0]        addr_b,
  input logic [AW-1:0]        result_x,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [1:0]           cmd_op,
  input logic [AW-1:0]        cmd_addr,
  input logic                 chk_req,
  input logic                 chk_ack,
  input logic                 chk_fault,
  input logic [AW-PAGE_W-1:0] chk_page
);
  localparam int KW = $clog2(BUDGET + 2);

  logic [AW-1:0]        a_l, b_l;
  logic [AW-PAGE_W-1:0] pg_l;
  logic                 pg_ok;
  logic [KW-1:0]        sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_l <= '0; b_l <= '0; pg_l <= '0; pg_ok <= 1'b0; sent <= '0;
    end else begin
      if (start && !busy) begin
        a_l <= addr_a; b_l <= addr_b; pg_ok <= 1'b0; sent <= '0;
      end else begin
        if (chk_req && chk_ack) begin
          pg_l  <= chk_page;
          pg_ok <= !chk_fault;
        end
        if (cmd_valid && cmd_ready && sent != KW'(BUDGET + 1))
          sent <= sent + KW'(1);
      end
    end
  end

  // R5: commands per call stay within the budget
  a_r5_budget: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= KW'(BUDGET));

  // R5, R1: returned address stays inside the range, or equals B when empty
  a_r5_x_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> ((b_l <= a_l) ? (result_x == b_l)
                                        : (result_x >= a_l && result_x <= b_l)));

  // R8: a fault reports an address inside a non-empty range
  a_r8_fault_x: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (result_x >= a_l && result_x < b_l));

  // R7: every command lies in a page that passed its check
  a_r7_page_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (pg_ok && cmd_addr[AW-1:PAGE_W] == pg_l));

  // R11: a pending command holds until accepted
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_op)));

  // R12: done is a single-cycle strobe
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: coherent configuration stays silent on both request channels
  a_r9_coh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (COHERENT != 1'b0) |-> (!cmd_valid && !chk_req));
endmodule

bind lms_range_seq lms_range_seq_chk #(
  .AW(AW), .PAGE_W(PAGE_W), .BUDGET(BUDGET), .COHERENT(COHERENT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault(fault), .addr_a(addr_a), .addr_b(addr_b), .result_x(result_x),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .chk_req(chk_req), .chk_ack(chk_ack),
  .chk_fault(chk_fault), .chk_page(chk_page)
);

// File: tb/lms_range_seq_test.sv
module lms_range_seq_test;
  localparam int AW = 12, LW = 4, PW = 6, BG = 3, LB = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  int   n_chk = 0, n_fail = 0;

  // main instance signals
  logic          start, busy, done, fault, cmd_valid, cmd_ready, chk_req, chk_ack, chk_fault;
  logic [1:0]    op, cmd_op;
  logic [AW-1:0] addr_a, addr_b, result_x, cmd_addr;
  logic [AW-PW-1:0] chk_page;

  // coherent instance signals
  logic          start_c, busy_c, done_c, fault_c, cmdv_c, chkr_c;
  logic [1:0]    cmdop_c;
  logic [AW-1:0] x_c, cmda_c;
  logic [AW-PW-1:0] chkp_c;

  // resume-pointer instance signals
  logic          start_t, busy_t, done_t, fault_t, cmdv_t, chkr_t;
  logic [1:0]    cmdop_t;
  logic [AW-1:0] x_t, cmda_t;
  logic [AW-PW-1:0] chkp_t;

  lms_range_seq #(.AW(AW), .LINE_W(LW), .PAGE_W(PW), .BUDGET(BG)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr_a(addr_a), .addr_b(addr_b),
    .busy(busy), .done(done), .result_x(result_x), .fault(fault),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .chk_req(chk_req), .chk_ack(chk_ack), .chk_fault(chk_fault), .chk_page(chk_page));

  lms_range_seq #(.AW(AW), .LINE_W(LW), .PAGE_W(PW), .BUDGET(BG), .COHERENT(1'b1)) uut_coh (
    .clk(clk), .rst_n(rst_n), .start(start_c), .op(op), .addr_a(addr_a), .addr_b(addr_b),
    .busy(busy_c), .done(done_c), .result_x(x_c), .fault(fault_c),
    .cmd_valid(cmdv_c), .cmd_ready(1'b1), .cmd_op(cmdop_c), .cmd_addr(cmda_c),
    .chk_req(chkr_c), .chk_ack(1'b1), .chk_fault(1'b0), .chk_page(chkp_c));

  lms_range_seq #(.AW(AW), .LINE_W(LW), .PAGE_W(PW), .BUDGET(BG), .TRACK_INTERNAL(1'b1)) uut_trk (
    .clk(clk), .rst_n(rst_n), .start(start_t), .op(op), .addr_a(addr_a), .addr_b(addr_b),
    .busy(busy_t), .done(done_t), .result_x(x_t), .fault(fault_t),
    .cmd_valid(cmdv_t), .cmd_ready(1'b1), .cmd_op(cmdop_t), .cmd_addr(cmda_t),
    .chk_req(chkr_t), .chk_ack(1'b1), .chk_fault(1'b0), .chk_page(chkp_t));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // bench model state for the main instance
  int cur_op, cur_b, exp_cur, inv_cnt, flt_page, phase = 0;
  bit flt_en = 0, pg_seen = 0, last_flt = 0, hold_cmd = 0;
  int last_pg, hold_addr, hold_op;

  // controller and translation responders, acting at the falling edge
  always @(negedge clk) begin
    phase++;
    if (hold_cmd)
      check(cmd_valid && cmd_addr == AW'(hold_addr) && cmd_op == 2'(hold_op),
            "R11 held command", int'(cmd_addr), hold_addr);
    hold_cmd  = 0;
    cmd_ready = 1'b0;
    chk_ack   = 1'b0;
    chk_fault = 1'b0;
    if (chk_req && (phase % 2 == 0)) begin
      chk_ack   = 1'b1;
      chk_fault = flt_en && int'(chk_page) == flt_page;
      check(int'(chk_page) == (exp_cur >> PW), "R7 checked page", int'(chk_page), exp_cur >> PW);
      last_pg  = int'(chk_page);
      last_flt = chk_fault;
      pg_seen  = 1;
    end
    if (cmd_valid) begin
      if (phase % 3 == 0) begin
        hold_cmd  = 1;
        hold_addr = int'(cmd_addr);
        hold_op   = int'(cmd_op);
      end else begin
        int line, nxt, eop;
        bit part;
        cmd_ready = 1'b1;
        line = exp_cur & ~(LB - 1);
        nxt  = line + LB;
        part = (exp_cur % LB != 0) || (nxt > cur_b);
        eop  = (cur_op == 2 && part) ? 1 : cur_op;
        check(int'(cmd_addr) == line, "R2 line address", int'(cmd_addr), line);
        if (cur_op == 2 && part) check(int'(cmd_op) == eop, "R4 partial invalidate", int'(cmd_op), eop);
        else                     check(int'(cmd_op) == eop, "R3 line op", int'(cmd_op), eop);
        check(inv_cnt < BG, "R5 budget", inv_cnt + 1, BG);
        check(pg_seen && !last_flt && last_pg == (line >> PW), "R7 page cleared", last_pg, line >> PW);
        exp_cur = (nxt > cur_b) ? cur_b : nxt;
        inv_cnt++;
      end
    end
  end

  // coherent instance monitor and resume-pointer command model
  bit coh_req_seen = 0;
  int t_exp = 0, t_cnt = 0;
  always @(negedge clk) begin
    if (cmdv_c || chkr_c) coh_req_seen = 1;
    if (cmdv_t) begin
      check(int'(cmda_t) == t_exp, "R10 resumed line", int'(cmda_t), t_exp);
      t_exp += LB;
      t_cnt++;
    end
  end

  int res_x;
  bit res_f;

  task automatic call_main(input int a);
    int k;
    @(negedge clk);
    addr_a  = AW'(a);
    addr_b  = AW'(cur_b);
    op      = 2'(cur_op);
    inv_cnt = 0;
    pg_seen = 0;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 200) begin @(negedge clk); k++; end
    check(done, "R6 call ends", 0, 1);
    res_x = int'(result_x);
    res_f = fault;
    @(negedge clk);
    check(!done && int'(result_x) == res_x && fault == res_f, "R12 done pulse and hold",
          int'(result_x), res_x);
  endtask

  task automatic run_seq(input int o, input int a0, input int b0, input bit fe, input int fp);
    int xa;
    xa = a0; cur_op = o; cur_b = b0; exp_cur = a0; flt_en = fe; flt_page = fp;
    for (int it = 0; it < 40; it++) begin
      call_main(xa);
      if (res_f) begin
        check(fe && (exp_cur >> PW) == fp && res_x == exp_cur, "R8 fault stop", res_x, exp_cur);
        return;
      end
      if (b0 <= xa)          check(res_x == b0 && inv_cnt == 0, "R1 empty range", res_x, b0);
      else if (exp_cur == b0) check(res_x == b0, "R5 final X", res_x, b0);
      else                    check(res_x == exp_cur && inv_cnt == BG, "R5 partial X", res_x, exp_cur);
      xa = res_x;
      if (xa == b0) begin
        check(b0 <= a0 || exp_cur == b0, "R6 full coverage", exp_cur, b0);
        return;
      end
    end
    check(0, "R6 loop terminates", xa, b0);
  endtask

  task automatic call_trk(input int a, input int b, input int exp_x, input int exp_n);
    int k;
    @(negedge clk);
    addr_a = AW'(a); addr_b = AW'(b); op = 2'd0; t_cnt = 0; start_t = 1'b1;
    @(negedge clk);
    start_t = 1'b0;
    k = 0;
    while (!done_t && k < 100) begin @(negedge clk); k++; end
    check(done_t && int'(x_t) == exp_x, "R10 returned X", int'(x_t), exp_x);
    check(t_cnt == exp_n, "R10 lines per call", t_cnt, exp_n);
  endtask

  task automatic call_coh(input int a, input int b);
    @(negedge clk);
    addr_a = AW'(a); addr_b = AW'(b); op = 2'd1; start_c = 1'b1;
    @(negedge clk);
    start_c = 1'b0;
    check(done_c && int'(x_c) == b && !fault_c, "R9 coherent returns B", int'(x_c), b);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_c = 1'b0; start_t = 1'b0;
    op = 2'd0; addr_a = '0; addr_b = '0;
    cmd_ready = 1'b0; chk_ack = 1'b0; chk_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !cmd_valid && !chk_req && !fault, "R12 reset state", int'(busy), 0);

    // sweep of operations over start/end grid, including B <= A
    for (int o = 0; o < 3; o++)
      for (int a = 0; a <= 70; a += 5)
        for (int b = 0; b <= 100; b += 7)
          run_seq(o, a, b, 1'b0, 0);

    // aligned full lines under invalidate keep code 2 (R3)
    run_seq(2, 32'h20, 32'h60, 1'b0, 0);
    // top of address space: last line boundary carries out
    run_seq(2, 32'hFF5, 32'hFFF, 1'b0, 0);
    run_seq(0, 32'hF80, 32'hFFF, 1'b0, 0);

    // fault on page 2 (bytes 0x80..0xBF)
    run_seq(1, 32'h05, 32'hC0, 1'b1, 2);
    check(res_f && res_x == 32'h80, "R8 fault address", res_x, 32'h80);

    // coherent configuration
    call_coh(32'h10, 32'h80);
    call_coh(32'h80, 32'h10);
    check(!coh_req_seen, "R9 no requests", int'(coh_req_seen), 0);

    // resume pointer: 8 lines, budget 3
    t_exp = 32'h10;
    call_trk(32'h10, 32'h90, 32'h10, 3);
    call_trk(32'h10, 32'h90, 32'h10, 3);
    call_trk(32'h10, 32'h90, 32'h90, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule